// File: doc/BRIEF.md
# MAC Statistics Counter Bank with Carry Flags

This block counts error and collision events reported by an Ethernet MAC. Each of fourteen event strobes drives its own counter. Receive-side error counters use a wide width and the remaining counters use a narrow width. When any counter rolls over from all-ones to zero, the block latches one bit in one of two carry registers and then keeps counting. Host software reads a carry register to see which counters have wrapped and adds one full revolution to its own extended copy of each of those counts.

Each carry register has a mask register beside it. The single interrupt output is high while any carry bit is set whose mask bit is zero. All counters, both carry registers and both masks sit behind one word-wide register port. That port has a read strobe, a write strobe and a read-data register with a latency of one cycle. Reading a carry register clears it. A rollover that lands in the same cycle as a clear is never lost.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset, every counter and both carry registers read 0, mask register 1 reads 0xFFFFBE32, mask register 2 reads 0xFFFE7E8B, and the interrupt is low.
- R2: Each cycle in which event strobe k is high adds one to counter k.
  - Counters 0 to 4 and counter 6 are WIDE_W bits wide.
  - Counters 5 and 7 to 13 are NARROW_W bits wide.
  - Counter values read back zero-extended to 32 bits.
- R3: An event that takes a counter from all-ones to zero sets that counter's carry bit in the same clock edge. The counter then continues counting from zero.
- R4: Carry register 1 holds counters 0 to 6 at bit positions 0, 2, 3, 6, 7, 8, 14 in that order. Carry register 2 holds counters 7 to 13 at bit positions 2, 4, 5, 6, 8, 15, 16 in that order. No other carry bit ever becomes set.
- R5: A read of a carry register returns its value before the read and clears it. A carry bit set by a wrap in the same cycle as the read stays set.
- R6: A write to a carry register clears each bit whose write-data bit is 0 and cannot set any bit. A wrap in the same cycle as the write wins.
- R7: A write to counter k loads the low bits of the write data. If event k arrives in the same cycle, the counter takes the written value plus one, and a written all-ones value wraps to zero and sets the carry bit.
- R8: Both mask registers are fully readable and writable. The interrupt is high exactly while some carry bit is 1 and its mask bit is 0.
- R9: Read data appears on the cycle after the read strobe and holds until the next read. Unmapped addresses read 0.
- R10: The address map is as follows: counters 0 to 13 at addresses 0 to 13, carry register 1 at 16, carry register 2 at 17, mask register 1 at 18, mask register 2 at 19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_i | input | 14 | Per-counter event strobes, one count per high cycle |
| addr_i | input | 5 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Unmasked carry interrupt |

## Verification
The bench builds the block with NARROW_W = 4 and WIDE_W = 6. At those widths every counter rolls over within 64 events. It also presets each counter to all-ones through a write, so the bench drives every counter through its rollover and checks each carry bit at its own position. The short widths also make it cheap to line up a rollover with a carry read, with a carry write and with a counter load in the same cycle. Those collisions are the cases where a lost wrap would hide.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

    localparam int NUM_EV    = 14;
    localparam int GRP_SPLIT = 7;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;

    // counters that use the wide width (1 = wide)
    localparam logic [NUM_EV-1:0] WIDE_SEL = 14'h005F;

    // carry bit position of each counter inside its carry register
    localparam int CARRY_POS [NUM_EV] = '{0, 2, 3, 6, 7, 8, 14,
                                          2, 4, 5, 6, 8, 15, 16};

    localparam logic [ADDR_W-1:0] A_CARRY1 = 5'd16;
    localparam logic [ADDR_W-1:0] A_CARRY2 = 5'd17;
    localparam logic [ADDR_W-1:0] A_MASK1  = 5'd18;
    localparam logic [ADDR_W-1:0] A_MASK2  = 5'd19;

    localparam logic [DATA_W-1:0] MASK1_RST = 32'hFFFF_BE32;
    localparam logic [DATA_W-1:0] MASK2_RST = 32'hFFFE_7E8B;

    typedef struct packed {
        logic [DATA_W-1:0] carry1;
        logic [DATA_W-1:0] carry2;
        logic [DATA_W-1:0] mask1;
        logic [DATA_W-1:0] mask2;
    } carry_state_t;

    // positions that a group may ever set
    function automatic logic [DATA_W-1:0] legal_bits(input bit second);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if ((i >= GRP_SPLIT) == second) m[CARRY_POS[i]] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mac_stat_counter.sv
module mac_stat_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] base;

    // load and increment share one adder: a load in the same cycle as an
    // event counts the event on top of the loaded value
    always_comb begin
        base   = load_i ? load_val_i : cnt_q;
        cnt_d  = base + {{(W-1){1'b0}}, inc_i};
        wrap_o = inc_i && (base == {W{1'b1}});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/mac_stat_carry.sv
module mac_stat_carry
    import mac_stat_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_EV-1:0] wrap_i,
    input  logic              rd1_i,
    input  logic              rd2_i,
    input  logic              wr1_i,
    input  logic              wr2_i,
    input  logic              wrm1_i,
    input  logic              wrm2_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] carry1_o,
    output logic [DATA_W-1:0] carry2_o,
    output logic [DATA_W-1:0] mask1_o,
    output logic [DATA_W-1:0] mask2_o,
    output logic [DATA_W-1:0] set1_o,
    output logic [DATA_W-1:0] set2_o,
    output logic              irq_o
);

    carry_state_t st_d, st_q;
    logic [DATA_W-1:0] set1, set2;

    always_comb begin
        set1 = '0;
        set2 = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (wrap_i[i]) begin
                if (i < GRP_SPLIT) set1[CARRY_POS[i]] = 1'b1;
                else               set2[CARRY_POS[i]] = 1'b1;
            end
        end

        st_d = st_q;
        // clears first, then fresh wraps on top so none is lost
        if (rd1_i) st_d.carry1 = '0;
        if (wr1_i) st_d.carry1 = st_d.carry1 & wdata_i;
        st_d.carry1 = st_d.carry1 | set1;

        if (rd2_i) st_d.carry2 = '0;
        if (wr2_i) st_d.carry2 = st_d.carry2 & wdata_i;
        st_d.carry2 = st_d.carry2 | set2;

        if (wrm1_i) st_d.mask1 = wdata_i;
        if (wrm2_i) st_d.mask2 = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.carry1 <= '0;
            st_q.carry2 <= '0;
            st_q.mask1  <= MASK1_RST;
            st_q.mask2  <= MASK2_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry1_o = st_q.carry1;
    assign carry2_o = st_q.carry2;
    assign mask1_o  = st_q.mask1;
    assign mask2_o  = st_q.mask2;
    assign set1_o   = set1;
    assign set2_o   = set2;
    assign irq_o    = (|(st_q.carry1 & ~st_q.mask1)) | (|(st_q.carry2 & ~st_q.mask2));

endmodule

// File: rtl/mac_stat_regif.sv
module mac_stat_regif
    import mac_stat_pkg::*;
(
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          wr_en_i,
    input  logic                          rd_en_i,
    input  logic [NUM_EV-1:0][DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0]             carry1_i,
    input  logic [DATA_W-1:0]             carry2_i,
    input  logic [DATA_W-1:0]             mask1_i,
    input  logic [DATA_W-1:0]             mask2_i,
    output logic [NUM_EV-1:0]             cnt_wr_o,
    output logic                          rd1_o,
    output logic                          rd2_o,
    output logic                          wr1_o,
    output logic                          wr2_o,
    output logic                          wrm1_o,
    output logic                          wrm2_o,
    output logic [DATA_W-1:0]             rdata_o
);

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        cnt_wr_o = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (wr_en_i && addr_i == ADDR_W'(i)) cnt_wr_o[i] = 1'b1;
        end
        wr1_o  = wr_en_i && addr_i == A_CARRY1;
        wr2_o  = wr_en_i && addr_i == A_CARRY2;
        wrm1_o = wr_en_i && addr_i == A_MASK1;
        wrm2_o = wr_en_i && addr_i == A_MASK2;
        rd1_o  = rd_en_i && addr_i == A_CARRY1;
        rd2_o  = rd_en_i && addr_i == A_CARRY2;

        rdata_d = rdata_q;
        if (rd_en_i) begin
            rdata_d = '0;
            for (int i = 0; i < NUM_EV; i++) begin
                if (addr_i == ADDR_W'(i)) rdata_d = cnt_i[i];
            end
            case (addr_i)
                A_CARRY1: rdata_d = carry1_i;
                A_CARRY2: rdata_d = carry2_i;
                A_MASK1:  rdata_d = mask1_i;
                A_MASK2:  rdata_d = mask2_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int NARROW_W = 12,
    parameter int WIDE_W   = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_EV-1:0]    ev_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o
);

    logic [NUM_EV-1:0][DATA_W-1:0] cnt_ext;
    logic [NUM_EV-1:0]             cnt_wr;
    logic [NUM_EV-1:0]             wrap;
    logic [DATA_W-1:0]             carry1, carry2, mask1, mask2, set1, set2;
    logic                          rd1, rd2, wr1, wr2, wrm1, wrm2;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
        localparam int W = WIDE_SEL[g] ? WIDE_W : NARROW_W;
        logic [W-1:0] cnt;

        mac_stat_counter #(.W(W)) i_cnt (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .inc_i      (ev_i[g]),
            .load_i     (cnt_wr[g]),
            .load_val_i (wdata_i[W-1:0]),
            .cnt_o      (cnt),
            .wrap_o     (wrap[g])
        );

        assign cnt_ext[g] = DATA_W'(cnt);
    end

    mac_stat_carry i_carry (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wrap_i   (wrap),
        .rd1_i    (rd1),
        .rd2_i    (rd2),
        .wr1_i    (wr1),
        .wr2_i    (wr2),
        .wrm1_i   (wrm1),
        .wrm2_i   (wrm2),
        .wdata_i  (wdata_i),
        .carry1_o (carry1),
        .carry2_o (carry2),
        .mask1_o  (mask1),
        .mask2_o  (mask2),
        .set1_o   (set1),
        .set2_o   (set2),
        .irq_o    (irq_o)
    );

    mac_stat_regif i_regif (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .cnt_i    (cnt_ext),
        .carry1_i (carry1),
        .carry2_i (carry2),
        .mask1_i  (mask1),
        .mask2_i  (mask2),
        .cnt_wr_o (cnt_wr),
        .rd1_o    (rd1),
        .rd2_o    (rd2),
        .wr1_o    (wr1),
        .wr2_o    (wr2),
        .wrm1_o   (wrm1),
        .wrm2_o   (wrm2),
        .rdata_o  (rdata_o)
    );

endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk
    import mac_stat_pkg::*;
#(
    parameter int NARROW_W = 12,
    parameter int WIDE_W   = 16
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [NUM_EV-1:0]             ev_i,
    input logic [ADDR_W-1:0]             addr_i,
    input logic                          wr_en_i,
    input logic                          rd_en_i,
    input logic [DATA_W-1:0]             rdata_o,
    input logic                          irq_o,
    input logic [NUM_EV-1:0][DATA_W-1:0] cnt_i,
    input logic [DATA_W-1:0]             carry1_i,
    input logic [DATA_W-1:0]             carry2_i,
    input logic [DATA_W-1:0]             mask1_i,
    input logic [DATA_W-1:0]             mask2_i,
    input logic [DATA_W-1:0]             set1_i,
    input logic [DATA_W-1:0]             set2_i
);

    localparam logic [DATA_W-1:0] LEGAL1 = legal_bits(1'b0);
    localparam logic [DATA_W-1:0] LEGAL2 = legal_bits(1'b1);

    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        localparam int W = WIDE_SEL[g] ? WIDE_W : NARROW_W;
        localparam logic [DATA_W-1:0] CMASK = DATA_W'({W{1'b1}});
        logic own_wr;
        assign own_wr = wr_en_i && addr_i == ADDR_W'(g);

        assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ev_i[g] && !own_wr) |=> cnt_i[g] == (($past(cnt_i[g]) + 1) & CMASK));

        assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!ev_i[g] && !own_wr) |=> $stable(cnt_i[g]));
    end

    assert_carry_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((carry1_i & ~LEGAL1) == '0) && ((carry2_i & ~LEGAL2) == '0));

    assert_wrap_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set1_i != '0 || set2_i != '0) |=>
        ((carry1_i & $past(set1_i)) == $past(set1_i)) &&
        ((carry2_i & $past(set2_i)) == $past(set2_i)));

    assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == A_CARRY1 && !wr_en_i && set1_i == '0) |=> carry1_i == '0);

    assert_irq_needs_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (carry1_i != '0 || carry2_i != '0));

    assert_irq_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(carry1_i) && $stable(carry2_i) && $stable(mask1_i) && $stable(mask2_i))
        |-> $stable(irq_o));

    assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

endmodule

bind mac_stat_bank mac_stat_bank_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_i),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .cnt_i    (cnt_ext),
    .carry1_i (carry1),
    .carry2_i (carry2),
    .mask1_i  (mask1),
    .mask2_i  (mask2),
    .set1_i   (set1),
    .set2_i   (set2)
);

// File: tb/test_mac_stat_bank.sv
`timescale 1ns/1ps
module test_mac_stat_bank;

    localparam int NW = 4;
    localparam int WW = 6;
    localparam int NEV = 14;
    localparam int POS [NEV] = '{0, 2, 3, 6, 7, 8, 14, 2, 4, 5, 6, 8, 15, 16};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ev = '0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mac_stat_bank #(.NARROW_W(NW), .WIDE_W(WW)) i_mac_stat_bank (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .ev_i    (ev),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    function automatic int width_of(int k);
        return (k <= 4 || k == 6) ? WW : NW;
    endfunction

    function automatic logic [31:0] ones_of(int k);
        return 32'((1 << width_of(k)) - 1);
    endfunction

    function automatic logic [4:0] carry_addr(int k);
        return (k < 7) ? 5'd16 : 5'd17;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [13:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'd0);
        for (int k = 0; k < NEV; k++) begin
            rd(5'(k), v);
            chk("R1 counter", v, 32'd0);
        end
        rd(5'd16, v); chk("R1 carry1", v, 32'd0);
        rd(5'd17, v); chk("R1 carry2", v, 32'd0);
        rd(5'd18, v); chk("R1 mask1", v, 32'hFFFF_BE32);
        rd(5'd19, v); chk("R1 mask2", v, 32'hFFFE_7E8B);
    endtask

    task automatic t_count;
        logic [31:0] v;
        for (int n = 0; n < 3; n++) pulse(14'h1 << 10);
        rd(5'd10, v); chk("R2 three pulses", v, 32'd3);
        pulse(14'h3FFF);
        for (int k = 0; k < NEV; k++) begin
            rd(5'(k), v);
            chk("R2 all strobes", v, (k == 10) ? 32'd4 : 32'd1);
        end
        @(negedge clk); ev = 14'h1;
        @(negedge clk);
        @(negedge clk); ev = '0;
        rd(5'd0, v); chk("R2 held two cycles", v, 32'd3);
    endtask

    task automatic t_wrap_each;
        logic [31:0] v;
        for (int k = 0; k < NEV; k++) begin
            wr(5'(k), ones_of(k));
            rd(5'(k), v); chk("R7 load", v, ones_of(k));
            pulse(14'h1 << k);
            chk("R8 irq after wrap", {31'b0, irq}, 32'd1);
            rd(5'(k), v); chk("R3 wrapped to zero", v, 32'd0);
            rd(carry_addr(k), v); chk("R4 carry position", v, 32'h1 << POS[k]);
            chk("R5 irq after clear", {31'b0, irq}, 32'd0);
            rd(carry_addr(k), v); chk("R5 cleared by read", v, 32'd0);
            pulse(14'h1 << k);
            rd(5'(k), v); chk("R3 keeps counting", v, 32'd1);
        end
    endtask

    task automatic t_read_race;
        logic [31:0] v;
        wr(5'd0, ones_of(0));
        @(negedge clk);
        addr = 5'd16; rd_en = 1'b1; ev = 14'h1;
        @(negedge clk);
        rd_en = 1'b0; ev = '0;
        chk("R5 read returns pre-wrap value", rdata, 32'd0);
        rd(5'd16, v); chk("R5 wrap survives read", v, 32'h1);
    endtask

    task automatic t_write_clear;
        logic [31:0] v;
        wr(5'd0, ones_of(0));
        wr(5'd6, ones_of(6));
        pulse(14'h41);
        wr(5'd16, ~32'h1);
        rd(5'd16, v); chk("R6 selective clear", v, 32'h1 << 14);
        wr(5'd17, 32'hFFFF_FFFF);
        rd(5'd17, v); chk("R6 write cannot set", v, 32'd0);
        wr(5'd8, ones_of(8));
        @(negedge clk);
        addr = 5'd17; wdata = 32'd0; wr_en = 1'b1; ev = 14'h1 << 8;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        rd(5'd17, v); chk("R6 wrap beats write", v, 32'h1 << 4);
    endtask

    task automatic t_load_inc;
        logic [31:0] v;
        @(negedge clk);
        addr = 5'd3; wdata = 32'd5; wr_en = 1'b1; ev = 14'h1 << 3;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        rd(5'd3, v); chk("R7 load plus event", v, 32'd6);
        @(negedge clk);
        addr = 5'd12; wdata = ones_of(12); wr_en = 1'b1; ev = 14'h1 << 12;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        rd(5'd12, v); chk("R7 load ones plus event", v, 32'd0);
        rd(5'd17, v); chk("R7 carry from loaded wrap", v, 32'h1 << 15);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(5'd18, 32'hFFFF_FFFF);
        rd(5'd18, v); chk("R8 mask1 readback", v, 32'hFFFF_FFFF);
        wr(5'd1, ones_of(1));
        pulse(14'h1 << 1);
        chk("R8 masked carry no irq", {31'b0, irq}, 32'd0);
        wr(5'd18, ~(32'h1 << 2));
        chk("R8 unmask raises irq", {31'b0, irq}, 32'd1);
        wr(5'd19, 32'h0);
        rd(5'd19, v); chk("R8 mask2 readback", v, 32'd0);
        rd(5'd16, v); chk("R8 carry seen", v, 32'h1 << 2);
        chk("R8 irq low after read", {31'b0, irq}, 32'd0);
        wr(5'd18, 32'hFFFF_BE32);
        wr(5'd19, 32'hFFFE_7E8B);
    endtask

    task automatic t_map;
        logic [31:0] v;
        rd(5'd15, v); chk("R9 unmapped 15", v, 32'd0);
        rd(5'd20, v); chk("R9 unmapped 20", v, 32'd0);
        rd(5'd31, v); chk("R10 unmapped 31", v, 32'd0);
        rd(5'd19, v); chk("R10 mask2 at 19", v, 32'hFFFE_7E8B);
        repeat (3) @(negedge clk);
        chk("R9 rdata held", rdata, 32'hFFFE_7E8B);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_wrap_each();
        t_read_race();
        t_write_clear();
        t_load_inc();
        t_mask();
        t_map();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule